// File: doc/BRIEF.md
# Packet Transfer-Command Engine

This block stages a single packet for a removable-card host controller and launches one transfer command per packet. Software reaches the packet buffer through a 32-bit programmed-I/O window that packs bytes big-endian: the first packet byte travels in the most significant lane. A direction flag in an I/O control word sets which way the data moves. A single write to the command word then starts the transfer. That word carries the byte count, a large-buffer select and a 4-bit command code.

For an outbound command the engine streams the staged bytes one at a time to a byte-wide card-side port that has a valid/ready handshake. For an inbound command it stores the bytes that the card side presents, and software then drains them through the same window. When the last byte has moved, a ready status bit sets. Two sticky status bits record send and receive failures that the card side reports while a command is in flight. The line encoding and CRC logic sit outside this block, on its card side.

Top module: `pkt_xfer_engine`

## Requirements
- R1: After reset the status word is zero, `tx_valid` and `cmd_start` are low, and a window read returns zero.
- R2: Window words are big-endian: bits 31:24 of the first staged word are the first byte sent to the card side, then bits 23:16, 15:8 and 7:0, then the next word.
- R3: The command word is decoded as length in bits 25:16, large-buffer select in bit 26 and command code in bits 31:28. An accepted command pulses `cmd_start` for one cycle in the cycle after the write, with `cmd_code` and `cmd_len` holding the decoded fields.
- R4: With the direction flag (bit 24 of the I/O control word) at 1, exactly `length` bytes are offered on the card side, in buffer order.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` holds its value.
- R6: With the direction flag at 0, `length` bytes accepted on `rx_valid` are read back big-endian through the window. Unused low-order byte lanes of a trailing partial word read as zero.
- R7: A window read with no unread word left returns zero and pulses `pio_underrun` for one cycle.
- R8: On an outbound launch where the staged word count differs from the length rounded up to whole words, `len_mismatch` pulses for one cycle in the cycle after the write, and the command still moves `length` bytes.
- R9: A command whose length is 0 or above 512, or whose bit 26 is 0, moves no data and gives no `cmd_start`. Ready (status bit 28) reads 1 in the next cycle.
- R10: Status bit 24 (send failure) and bit 25 (receive failure) set when `card_send_err` or `card_recv_err` is asserted while a command is in flight. They stay set until the next command write or reset, and these inputs have no effect while idle.
- R11: Ready (status bit 28) reads 0 in the cycle after an accepted launch and reads 1 once the last byte has been transferred.
- R12: Every command write empties the buffer's read and write pointers, and a write arriving during a transfer restarts the engine on the new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pio_wr | input | 1 | Push one word into the buffer (ignored while busy or full) |
| pio_wdata | input | 32 | Word to push, first byte in bits 31:24 |
| pio_rd | input | 1 | Pop one word from the buffer (ignored while busy) |
| pio_rdata | output | 32 | Popped word, valid in the cycle after `pio_rd` |
| pio_underrun | output | 1 | One-cycle pulse: the pop found no unread word |
| ctl_wr | input | 1 | Write the I/O control word |
| ctl_wdata | input | 32 | I/O control word, bit 24 = outbound direction |
| cmd_wr | input | 1 | Write the command word and launch |
| cmd_wdata | input | 32 | Command word: code 31:28, large select 26, length 25:16 |
| status | output | 32 | Bit 28 ready, bit 25 receive failure, bit 24 send failure |
| len_mismatch | output | 1 | One-cycle pulse: staged words disagree with length |
| cmd_start | output | 1 | One-cycle pulse when an accepted command begins |
| cmd_code | output | 4 | Code of the current command |
| cmd_len | output | 10 | Byte length of the current command |
| tx_valid | output | 1 | Outbound byte available |
| tx_data | output | 8 | Outbound byte |
| tx_ready | input | 1 | Card side accepts the outbound byte |
| rx_valid | input | 1 | Inbound byte present |
| rx_data | input | 8 | Inbound byte |
| card_send_err | input | 1 | Card side reports an outbound failure |
| card_recv_err | input | 1 | Card side reports an inbound failure |

## Verification
The assertions assume that the card side keeps to its handshake: `rx_valid` is raised only during an inbound command, and `cmd_wr` is a single-cycle strobe that is never repeated in the cycle where `cmd_start` is high. The bench drives every strobe for one cycle only and raises `rx_valid` only after an inbound launch. It holds `tx_ready` low on purpose to exercise the hold rule. It asserts the error inputs both during a transfer and while idle, so that the sticky-bit assumptions are met in the first case and the ignore rule is tested in the second.

// File: rtl/pkt_xfer_pkg.sv
package pkt_xfer_pkg;
  localparam int CMD_LEN_LSB  = 16;
  localparam int CMD_LEN_W    = 10;
  localparam int CMD_BIG_BIT  = 26;
  localparam int CMD_CODE_LSB = 28;
  localparam int CMD_CODE_W   = 4;
  localparam int CTL_DIR_BIT  = 24;
  localparam int ST_SEND_ERR  = 24;
  localparam int ST_RECV_ERR  = 25;
  localparam int ST_READY     = 28;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_FETCH = 2'd1,
    S_SEND  = 2'd2,
    S_RECV  = 2'd3
  } eng_state_e;
endpackage

// File: rtl/pkt_buf_ram.sv
module pkt_buf_ram #(
  parameter int WORDS = 128,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [3:0]    be,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  // One RAM per byte lane so that byte enables map onto block RAM.
  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic [7:0] mem [WORDS];
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (we && be[l]) mem[waddr] <= wdata[8*l +: 8];
      if (re) q <= mem[raddr];
    end
    assign rdata[8*l +: 8] = q;
  end
endmodule

// File: rtl/pkt_cmd_ctrl.sv
module pkt_cmd_ctrl
  import pkt_xfer_pkg::*;
#(
  parameter int DEPTH_BYTES = 512,
  localparam int WORDS = DEPTH_BYTES / 4,
  localparam int AW = $clog2(WORDS),
  localparam int CW = CMD_LEN_W + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  pio_wr,
  input  logic [31:0]           pio_wdata,
  input  logic                  pio_rd,
  output logic [31:0]           pio_rdata,
  output logic                  pio_underrun,
  input  logic                  ctl_wr,
  input  logic [31:0]           ctl_wdata,
  input  logic                  cmd_wr,
  input  logic [31:0]           cmd_wdata,
  output logic [31:0]           status,
  output logic                  len_mismatch,
  output logic                  cmd_start,
  output logic [CMD_CODE_W-1:0] cmd_code,
  output logic [CMD_LEN_W-1:0]  cmd_len,
  output logic                  tx_valid,
  output logic [7:0]            tx_data,
  input  logic                  tx_ready,
  input  logic                  rx_valid,
  input  logic [7:0]            rx_data,
  input  logic                  card_send_err,
  input  logic                  card_recv_err,
  output logic                  ram_we,
  output logic [3:0]            ram_be,
  output logic [AW-1:0]         ram_waddr,
  output logic [31:0]           ram_wdata,
  output logic                  ram_re,
  output logic [AW-1:0]         ram_raddr,
  input  logic [31:0]           ram_rdata
);
  eng_state_e           state;
  logic                 dir_out;
  logic [CMD_LEN_W-1:0] bcnt, bcnt_nx;
  logic [AW:0]          fill, rp;
  logic                 rd_zero, ready, serr, rerr;

  // Command word decode
  logic [CMD_LEN_W-1:0]  c_len;
  logic [CMD_CODE_W-1:0] c_code;
  logic                  c_ok;
  logic [CW-1:0]         c_sum, lq_sum;
  logic                  unused_bits;

  assign c_len  = cmd_wdata[CMD_LEN_LSB +: CMD_LEN_W];
  assign c_code = cmd_wdata[CMD_CODE_LSB +: CMD_CODE_W];
  assign c_ok   = cmd_wdata[CMD_BIG_BIT] && (c_len != '0) &&
                  ({1'b0, c_len} <= CW'(DEPTH_BYTES));
  assign c_sum  = {1'b0, c_len} + CW'(3);
  assign lq_sum = {1'b0, cmd_len} + CW'(3);
  assign unused_bits = ^{cmd_wdata[27], cmd_wdata[15:0], ctl_wdata[31:25], ctl_wdata[23:0]};

  assign bcnt_nx = bcnt + 1'b1;
  wire idle   = (state == S_IDLE);
  wire has_wd = (rp < fill);

  // Shared RAM ports
  always_comb begin
    ram_we    = 1'b0;
    ram_be    = 4'hF;
    ram_waddr = fill[AW-1:0];
    ram_wdata = pio_wdata;
    if (!cmd_wr && idle && pio_wr && (fill < (AW+1)'(WORDS))) begin
      ram_we = 1'b1;
    end else if (!cmd_wr && state == S_RECV && rx_valid) begin
      ram_we    = 1'b1;
      ram_waddr = bcnt[AW+1:2];
      if (bcnt[1:0] == 2'd0) begin
        ram_wdata = {rx_data, 24'h0};   // first lane clears the padding lanes
      end else begin
        ram_wdata = {4{rx_data}};
        ram_be    = 4'b1000 >> bcnt[1:0];
      end
    end
  end

  assign ram_re    = !cmd_wr && ((idle && pio_rd && has_wd) || state == S_FETCH);
  assign ram_raddr = idle ? rp[AW-1:0] : bcnt[AW+1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      dir_out      <= 1'b0;
      bcnt         <= '0;
      fill         <= '0;
      rp           <= '0;
      rd_zero      <= 1'b1;
      ready        <= 1'b0;
      serr         <= 1'b0;
      rerr         <= 1'b0;
      pio_underrun <= 1'b0;
      len_mismatch <= 1'b0;
      cmd_start    <= 1'b0;
      cmd_code     <= '0;
      cmd_len      <= '0;
    end else begin
      pio_underrun <= 1'b0;
      len_mismatch <= 1'b0;
      cmd_start    <= 1'b0;
      if (ctl_wr) dir_out <= ctl_wdata[CTL_DIR_BIT];
      if (cmd_wr) begin
        bcnt <= '0;
        rp   <= '0;
        fill <= '0;
        serr <= 1'b0;
        rerr <= 1'b0;
        if (c_ok) begin
          cmd_len      <= c_len;
          cmd_code     <= c_code;
          cmd_start    <= 1'b1;
          ready        <= 1'b0;
          state        <= dir_out ? S_FETCH : S_RECV;
          len_mismatch <= dir_out && (CW'(fill) != CW'(c_sum >> 2));
        end else begin
          ready <= 1'b1;
          state <= S_IDLE;
        end
      end else begin
        if (!idle && card_send_err) serr <= 1'b1;
        if (!idle && card_recv_err) rerr <= 1'b1;
        unique case (state)
          S_IDLE: begin
            if (pio_wr && (fill < (AW+1)'(WORDS))) fill <= fill + 1'b1;
            if (pio_rd) begin
              rd_zero      <= !has_wd;
              pio_underrun <= !has_wd;
              if (has_wd) rp <= rp + 1'b1;
            end
          end
          S_FETCH: state <= S_SEND;
          S_SEND: if (tx_ready) begin
            bcnt <= bcnt_nx;
            if (bcnt_nx == cmd_len) begin
              state <= S_IDLE;
              ready <= 1'b1;
            end else if (bcnt[1:0] == 2'd3) begin
              state <= S_FETCH;
            end
          end
          S_RECV: if (rx_valid) begin
            bcnt <= bcnt_nx;
            if (bcnt_nx == cmd_len) begin
              state <= S_IDLE;
              ready <= 1'b1;
              fill  <= (AW+1)'(lq_sum >> 2);
              rp    <= '0;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign pio_rdata = rd_zero ? 32'h0 : ram_rdata;
  assign tx_valid  = (state == S_SEND);
  always_comb begin
    unique case (bcnt[1:0])
      2'd0: tx_data = ram_rdata[31:24];
      2'd1: tx_data = ram_rdata[23:16];
      2'd2: tx_data = ram_rdata[15:8];
      default: tx_data = ram_rdata[7:0];
    endcase
  end

  always_comb begin
    status = '0;
    status[ST_READY]    = ready;
    status[ST_SEND_ERR] = serr;
    status[ST_RECV_ERR] = rerr;
  end
endmodule

// File: rtl/pkt_xfer_engine.sv
module pkt_xfer_engine #(
  parameter int DEPTH_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        pio_wr,
  input  logic [31:0] pio_wdata,
  input  logic        pio_rd,
  output logic [31:0] pio_rdata,
  output logic        pio_underrun,
  input  logic        ctl_wr,
  input  logic [31:0] ctl_wdata,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] status,
  output logic        len_mismatch,
  output logic        cmd_start,
  output logic [3:0]  cmd_code,
  output logic [9:0]  cmd_len,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  input  logic        tx_ready,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        card_send_err,
  input  logic        card_recv_err
);
  localparam int WORDS = DEPTH_BYTES / 4;
  localparam int AW = $clog2(WORDS);

  logic          ram_we, ram_re;
  logic [3:0]    ram_be;
  logic [AW-1:0] ram_waddr, ram_raddr;
  logic [31:0]   ram_wdata, ram_rdata;

  pkt_buf_ram #(.WORDS(WORDS)) u_ram (
    .clk(clk), .we(ram_we), .be(ram_be), .waddr(ram_waddr), .wdata(ram_wdata),
    .re(ram_re), .raddr(ram_raddr), .rdata(ram_rdata)
  );

  pkt_cmd_ctrl #(.DEPTH_BYTES(DEPTH_BYTES)) u_ctrl (
    .clk(clk), .rst(rst),
    .pio_wr(pio_wr), .pio_wdata(pio_wdata), .pio_rd(pio_rd),
    .pio_rdata(pio_rdata), .pio_underrun(pio_underrun),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .status(status), .len_mismatch(len_mismatch),
    .cmd_start(cmd_start), .cmd_code(cmd_code), .cmd_len(cmd_len),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .card_send_err(card_send_err), .card_recv_err(card_recv_err),
    .ram_we(ram_we), .ram_be(ram_be), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .ram_re(ram_re), .ram_raddr(ram_raddr), .ram_rdata(ram_rdata)
  );
endmodule

// File: rtl/pkt_xfer_checker.sv
module pkt_xfer_checker #(
  parameter int DEPTH_BYTES = 512
) (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pio_rdata,
  input logic        pio_underrun,
  input logic        cmd_wr,
  input logic [31:0] cmd_wdata,
  input logic [31:0] status,
  input logic        cmd_start,
  input logic        tx_valid,
  input logic [7:0]  tx_data,
  input logic        tx_ready
);
  logic launch_ok;
  assign launch_ok = cmd_wr && cmd_wdata[26] && (cmd_wdata[25:16] != 10'd0) &&
                     ({1'b0, cmd_wdata[25:16]} <= 11'(DEPTH_BYTES));

  p_start_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && !cmd_wr) |=> !cmd_start);

  p_tx_busy_r4: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> !status[28]);

  p_tx_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !cmd_wr) |=> (tx_valid && $stable(tx_data)));

  p_underrun_zero_r7: assert property (@(posedge clk) disable iff (rst)
    pio_underrun |-> (pio_rdata == 32'h0));

  p_reject_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !cmd_wdata[26]) |=> (status[28] && !cmd_start));

  p_err_clear_r10: assert property (@(posedge clk) disable iff (rst)
    cmd_wr |=> (status[25:24] == 2'b00));

  p_launch_ready_low_r11: assert property (@(posedge clk) disable iff (rst)
    launch_ok |=> (!status[28] && cmd_start));
endmodule

bind pkt_xfer_engine pkt_xfer_checker #(.DEPTH_BYTES(DEPTH_BYTES)) u_chk (
  .clk(clk), .rst(rst), .pio_rdata(pio_rdata), .pio_underrun(pio_underrun),
  .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .status(status), .cmd_start(cmd_start),
  .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
);

// File: tb/pkt_xfer_engine_tb.sv
module pkt_xfer_engine_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        pio_wr, pio_rd, ctl_wr, cmd_wr;
  logic [31:0] pio_wdata, ctl_wdata, cmd_wdata;
  logic [31:0] pio_rdata, status;
  logic        pio_underrun, len_mismatch, cmd_start;
  logic [3:0]  cmd_code;
  logic [9:0]  cmd_len;
  logic        tx_valid, tx_ready, rx_valid, card_send_err, card_recv_err;
  logic [7:0]  tx_data, rx_data;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;
  logic [7:0] got [0:31];
  int ngot;

  always #10 clk = ~clk;

  pkt_xfer_engine u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cmdw(input logic [3:0] code, input int len, input bit big);
    return {code, 1'b0, big, 10'(len), 16'h0};
  endfunction

  task automatic tick(); @(negedge clk); endtask

  task automatic set_dir(input bit outb);
    ctl_wr = 1'b1; ctl_wdata = 32'(outb) << 24; tick(); ctl_wr = 1'b0;
  endtask

  task automatic push(input logic [31:0] w);
    pio_wr = 1'b1; pio_wdata = w; tick(); pio_wr = 1'b0;
  endtask

  task automatic pop(output logic [31:0] w, output logic und);
    pio_rd = 1'b1; tick(); pio_rd = 1'b0; w = pio_rdata; und = pio_underrun;
  endtask

  task automatic launch(input logic [31:0] c);
    cmd_wr = 1'b1; cmd_wdata = c; tick(); cmd_wr = 1'b0;
  endtask

  task automatic collect();
    ngot = 0;
    for (int i = 0; i < 2000; i++) begin
      if (status[28]) break;
      if (tx_valid && tx_ready && ngot < 32) begin got[ngot] = tx_data; ngot++; end
      tick();
    end
  endtask

  task automatic t_reset();
    logic [31:0] w; logic u;
    chk("R1 status", status, 32'h0);
    chk("R1 tx_valid", 32'(tx_valid), 32'h0);
    chk("R1 cmd_start", 32'(cmd_start), 32'h0);
    pop(w, u);
    chk("R1 read zero", w, 32'h0);
    chk("R7 underrun at reset", 32'(u), 32'h1);
  endtask

  task automatic t_write_pkt();
    set_dir(1'b1);
    push(32'h11223344); push(32'h55667788);
    tx_ready = 1'b1;
    launch(cmdw(4'hB, 6, 1'b1));
    chk("R3 cmd_start", 32'(cmd_start), 32'h1);
    chk("R3 cmd_code", 32'(cmd_code), 32'hB);
    chk("R3 cmd_len", 32'(cmd_len), 32'd6);
    chk("R11 ready low at launch", 32'(status[28]), 32'h0);
    chk("R8 no mismatch", 32'(len_mismatch), 32'h0);
    tick();
    chk("R3 start one cycle", 32'(cmd_start), 32'h0);
    collect();
    chk("R4 byte count", 32'(ngot), 32'd6);
    chk("R2 byte order", {got[0], got[1], got[2], got[3]}, 32'h11223344);
    chk("R2 second word", {16'h0, got[4], got[5]}, 32'h00005566);
    chk("R11 ready after last", 32'(status[28]), 32'h1);
  endtask

  task automatic t_backpressure();
    push(32'hA1B2C3D4);
    tx_ready = 1'b0;
    launch(cmdw(4'hD, 4, 1'b1));
    tick();
    for (int i = 0; i < 4; i++) begin
      chk("R5 hold valid", 32'(tx_valid), 32'h1);
      chk("R5 hold data", 32'(tx_data), 32'hA1);
      tick();
    end
    tx_ready = 1'b1;
    collect();
    chk("R5 count after stall", 32'(ngot), 32'd4);
    chk("R5 data after stall", {got[0], got[1], got[2], got[3]}, 32'hA1B2C3D4);
  endtask

  task automatic t_mismatch();
    push(32'hCAFEF00D);
    launch(cmdw(4'hC, 9, 1'b1));
    chk("R8 mismatch pulse", 32'(len_mismatch), 32'h1);
    tick();
    chk("R8 mismatch one cycle", 32'(len_mismatch), 32'h0);
    collect();
    chk("R8 length still used", 32'(ngot), 32'd9);
    chk("R8 first word sent", {got[0], got[1], got[2], got[3]}, 32'hCAFEF00D);
  endtask

  task automatic t_read_pkt();
    logic [31:0] w; logic u;
    set_dir(1'b0);
    launch(cmdw(4'h2, 5, 1'b1));
    for (int i = 0; i < 5; i++) begin
      chk("R11 ready low during read", 32'(status[28]), 32'h0);
      rx_valid = 1'b1; rx_data = 8'h10 + 8'(i); tick();
    end
    rx_valid = 1'b0;
    chk("R11 ready after read", 32'(status[28]), 32'h1);
    pop(w, u);
    chk("R6 first word", w, 32'h10111213);
    chk("R6 no underrun", 32'(u), 32'h0);
    pop(w, u);
    chk("R6 padded tail", w, 32'h14000000);
    pop(w, u);
    chk("R7 empty read zero", w, 32'h0);
    chk("R7 underrun pulse", 32'(u), 32'h1);
    tick();
    chk("R7 underrun one cycle", 32'(pio_underrun), 32'h0);
  endtask

  task automatic t_errors();
    set_dir(1'b1);
    push(32'h01020304);
    tx_ready = 1'b0;
    launch(cmdw(4'h9, 4, 1'b1));
    card_send_err = 1'b1; tick(); card_send_err = 1'b0;
    chk("R10 send err set", 32'(status[24]), 32'h1);
    chk("R10 recv err clear", 32'(status[25]), 32'h0);
    tx_ready = 1'b1;
    collect();
    chk("R10 send err sticky", 32'(status[24]), 32'h1);
    card_recv_err = 1'b1; tick(); card_recv_err = 1'b0;
    chk("R10 idle recv err ignored", 32'(status[25]), 32'h0);
    launch(cmdw(4'h9, 4, 1'b0));
    chk("R10 cleared by command", 32'(status[25:24]), 32'h0);
  endtask

  task automatic t_reject();
    launch(cmdw(4'hB, 600, 1'b1));
    chk("R9 too long ready", 32'(status[28]), 32'h1);
    chk("R9 too long no start", 32'(cmd_start), 32'h0);
    tick();
    chk("R9 too long no data", 32'(tx_valid), 32'h0);
    launch(cmdw(4'hB, 0, 1'b1));
    chk("R9 zero length no start", 32'(cmd_start), 32'h0);
    launch(cmdw(4'hB, 4, 1'b0));
    chk("R9 small select no start", 32'(cmd_start), 32'h0);
    chk("R9 small select ready", 32'(status[28]), 32'h1);
  endtask

  task automatic t_clear();
    logic [31:0] w; logic u;
    push(32'h12345678); push(32'h9ABCDEF0);
    tx_ready = 1'b1;
    launch(cmdw(4'hB, 8, 1'b1));
    collect();
    pop(w, u);
    chk("R12 buffer emptied by launch", 32'(u), 32'h1);
    set_dir(1'b0);
    launch(cmdw(4'h2, 4, 1'b1));
    rx_valid = 1'b1; rx_data = 8'h01; tick();
    rx_data = 8'h02; tick();
    rx_valid = 1'b0;
    launch(cmdw(4'h2, 2, 1'b1));
    chk("R12 restart ready low", 32'(status[28]), 32'h0);
    rx_valid = 1'b1; rx_data = 8'hAA; tick();
    rx_data = 8'hBB; tick();
    rx_valid = 1'b0;
    chk("R12 restart completes", 32'(status[28]), 32'h1);
    pop(w, u);
    chk("R12 restarted data", w, 32'hAABB0000);
    pop(w, u);
    chk("R12 one word only", 32'(u), 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; pio_wr = 0; pio_rd = 0; ctl_wr = 0; cmd_wr = 0;
    pio_wdata = 0; ctl_wdata = 0; cmd_wdata = 0; tx_ready = 0;
    rx_valid = 0; rx_data = 0; card_send_err = 0; card_recv_err = 0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_write_pkt();
    t_backpressure();
    t_mismatch();
    t_read_pkt();
    t_errors();
    t_reject();
    t_clear();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule